// File: doc/BRIEF.md
# Input Capture and Timer Event Flag Unit

This unit sits beside a free-running counter. It watches an external capture pin, brings it into the clock domain through a synchronizer, and looks for the edge direction picked by a select input. When that edge is seen, the unit stores the counter's current value in a capture register and raises a capture flag. Capture is suppressed while the capture register is serving as the counter's upper limit.

The unit also keeps a five-bit event flag register. The bits record an overflow, compare matches on three channels and a capture. Each flag stays set until software writes a one to it or until its interrupt is acknowledged. Each flag drives its own interrupt request, gated by a per-flag enable. Match channels B and C only set flags. The counter and the compare logic that produce the pulses are outside the unit.

Top module: `cap_flag_unit`

## Requirements
- R1: After reset, flags_o, irq_o and cap_val_o are all zero.
- R2: With cap_rise_i = 0 (the default) only a falling edge of the synchronized pin causes a capture. With cap_rise_i = 1 only a rising edge does. The opposite edge changes neither cap_val_o nor the capture flag.
- R3: A pin change that is stable before clock edge k is stored at edge k+2. cap_val_o takes the value count_i has at that edge, and flag bit 4 is set at the same edge. cap_val_o is unchanged after edge k+1.
- R4: While cap_is_top_i is high, a selected edge changes neither cap_val_o nor flag bit 4.
- R5: The flag bit positions are: bit 0 overflow (ovf_i), bit 1 match A, bit 2 match B, bit 3 match C, bit 4 capture. A one-cycle event pulse sets its bit at the next clock edge, and the bit then holds.
- R6: When clr_we_i is high, each one in clr_data_i clears the matching flag at the next edge. Zero bits leave their flags unchanged.
- R7: If a flag's event and a clear of that flag (by write or by acknowledge) arrive in the same cycle, the flag is set after the edge.
- R8: irq_o[k] is high exactly when flags_o[k] and irq_en_i[k] are both high. It follows without a register.
- R9: A high irq_ack_i[k] clears flag k at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | CNT_W | Running counter value |
| ovf_i | input | 1 | Counter returned to zero (pulse) |
| match_a_i | input | 1 | Compare match channel A (pulse) |
| match_b_i | input | 1 | Compare match channel B (pulse) |
| match_c_i | input | 1 | Compare match channel C (pulse) |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| cap_rise_i | input | 1 | Edge select: 0 falling, 1 rising |
| cap_is_top_i | input | 1 | Capture register is the counter limit; blocks capture |
| clr_we_i | input | 1 | Flag clear write strobe |
| clr_data_i | input | 5 | Write-one-to-clear mask |
| irq_en_i | input | 5 | Per-flag interrupt enable |
| irq_ack_i | input | 5 | Per-flag interrupt acknowledge |
| cap_val_o | output | CNT_W | Captured counter value |
| flags_o | output | 5 | Event flags |
| irq_o | output | 5 | Interrupt requests |

## Verification
The capture path is driven first with the non-selected edge and then with the selected edge, under both select values. This separates a correct edge-polarity decoder from one that captures on any change. The bench moves the counter value every cycle and checks the register both one edge early and on the expected edge, so a missing or extra synchronizer stage shows up as a wrong value. A table of flag vectors then mixes single and combined event pulses with write clears, zero writes, acknowledges and enable masks, including cycles where a set and a clear of the same bit coincide. This shows that the clear sources and the set priority act per bit and do not leak into neighbouring flags.

// File: rtl/cap_flag_pkg.sv
package cap_flag_pkg;
  localparam int unsigned NFLAG   = 5;
  localparam int unsigned FLG_OVF  = 0;
  localparam int unsigned FLG_CMPA = 1;
  localparam int unsigned FLG_CMPB = 2;
  localparam int unsigned FLG_CMPC = 3;
  localparam int unsigned FLG_CAP  = 4;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic sync_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= {STAGES{RST_VAL}};
    else         q <= {q[STAGES-2:0], pin_i};
  end

  assign sync_o = q[STAGES-1];
endmodule

// File: rtl/cap_edge.sv
module cap_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= sync_i;
  end

  assign rise   = sync_i & ~prev_q;
  assign fall   = ~sync_i & prev_q;
  assign edge_o = rise_sel_i ? rise : fall;
endmodule

// File: rtl/cap_reg.sv
module cap_reg #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic             block_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             evt_o,
  output logic [CNT_W-1:0] cap_val_o
);
  assign evt_o = edge_i & ~block_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_val_o <= '0;
    else if (evt_o) cap_val_o <= count_i;
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] irq_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flags_o[k] <= 1'b0;
      else if (set_i[k]) flags_o[k] <= 1'b1;  // set beats clear
      else if (clr_i[k]) flags_o[k] <= 1'b0;
    end
    assign irq_o[k] = flags_o[k] & en_i[k];
  end
endmodule

// File: rtl/cap_flag_unit.sv
module cap_flag_unit
  import cap_flag_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             ovf_i,
  input  logic             match_a_i,
  input  logic             match_b_i,
  input  logic             match_c_i,
  input  logic             cap_pin_i,
  input  logic             cap_rise_i,
  input  logic             cap_is_top_i,
  input  logic             clr_we_i,
  input  logic [4:0]       clr_data_i,
  input  logic [4:0]       irq_en_i,
  input  logic [4:0]       irq_ack_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic [4:0]       flags_o,
  output logic [4:0]       irq_o
);
  logic             pin_sync;
  logic             cap_edge_hit;
  logic             cap_evt;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] clr_vec;

  cap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (cap_pin_i),
    .sync_o(pin_sync)
  );

  cap_edge #(.RST_VAL(1'b0)) i_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (pin_sync),
    .rise_sel_i(cap_rise_i),
    .edge_o    (cap_edge_hit)
  );

  cap_reg #(.CNT_W(CNT_W)) i_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .edge_i   (cap_edge_hit),
    .block_i  (cap_is_top_i),
    .count_i  (count_i),
    .evt_o    (cap_evt),
    .cap_val_o(cap_val_o)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FLG_OVF]  = ovf_i;
    set_vec[FLG_CMPA] = match_a_i;
    set_vec[FLG_CMPB] = match_b_i;
    set_vec[FLG_CMPC] = match_c_i;
    set_vec[FLG_CAP]  = cap_evt;
  end

  assign clr_vec = ({NFLAG{clr_we_i}} & clr_data_i) | irq_ack_i;

  flag_reg #(.N(NFLAG)) i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .en_i   (irq_en_i),
    .flags_o(flags_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/cap_flag_checker.sv
module cap_flag_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] count_i,
  input logic             ovf_i,
  input logic             match_a_i,
  input logic             match_b_i,
  input logic             cap_is_top_i,
  input logic             cap_evt,
  input logic             clr_we_i,
  input logic [4:0]       clr_data_i,
  input logic [4:0]       irq_en_i,
  input logic [4:0]       irq_ack_i,
  input logic [CNT_W-1:0] cap_val_o,
  input logic [4:0]       flags_o,
  input logic [4:0]       irq_o
);
  a_r3_cap_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> (cap_val_o == $past(count_i)) && flags_o[4]);

  a_r4_top_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_is_top_i |=> $stable(cap_val_o));

  a_r5_ovf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> flags_o[0]);

  a_r6_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && clr_data_i[1] && !match_a_i) |=> !flags_o[1]);

  a_r6_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[2] && !(clr_we_i && clr_data_i[2]) && !irq_ack_i[2]) |=> flags_o[2]);

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_b_i && (irq_ack_i[2] || (clr_we_i && clr_data_i[2]))) |=> flags_o[2]);

  a_r8_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~(flags_o & irq_en_i)) == 5'b0));

  a_r9_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i[0] && !ovf_i) |=> !flags_o[0]);
endmodule

bind cap_flag_unit cap_flag_checker #(.CNT_W(CNT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .count_i     (count_i),
  .ovf_i       (ovf_i),
  .match_a_i   (match_a_i),
  .match_b_i   (match_b_i),
  .cap_is_top_i(cap_is_top_i),
  .cap_evt     (cap_evt),
  .clr_we_i    (clr_we_i),
  .clr_data_i  (clr_data_i),
  .irq_en_i    (irq_en_i),
  .irq_ack_i   (irq_ack_i),
  .cap_val_o   (cap_val_o),
  .flags_o     (flags_o),
  .irq_o       (irq_o)
);

// File: tb/test_cap_flag_unit.sv
module test_cap_flag_unit;
  localparam int unsigned CNT_W  = 16;
  localparam time         PERIOD = 10ns;
  localparam int unsigned NVEC   = 12;

  // {set[3:0]={c,b,a,ovf}, we, data[4:0], ack[4:0], en[4:0], exp_flags[4:0], exp_irq[4:0]}
  localparam logic [29:0] VEC [NVEC] = '{
    {4'b0001, 1'b0, 5'b00000, 5'b00000, 5'b00000, 5'b00001, 5'b00000}, // R5
    {4'b0010, 1'b0, 5'b00000, 5'b00000, 5'b00001, 5'b00011, 5'b00001}, // R5 R8
    {4'b1100, 1'b0, 5'b00000, 5'b00000, 5'b11111, 5'b01111, 5'b01111}, // R5 R8
    {4'b0000, 1'b1, 5'b00010, 5'b00000, 5'b11111, 5'b01101, 5'b01101}, // R6
    {4'b0000, 1'b1, 5'b00000, 5'b00000, 5'b00000, 5'b01101, 5'b00000}, // R6 zero write
    {4'b0000, 1'b0, 5'b00000, 5'b00001, 5'b11111, 5'b01100, 5'b01100}, // R9
    {4'b0100, 1'b1, 5'b00100, 5'b00000, 5'b00000, 5'b01100, 5'b00000}, // R7 write
    {4'b0001, 1'b0, 5'b00000, 5'b00001, 5'b00000, 5'b01101, 5'b00000}, // R7 ack
    {4'b0000, 1'b1, 5'b11111, 5'b00000, 5'b00000, 5'b00000, 5'b00000}, // R6
    {4'b1111, 1'b0, 5'b00000, 5'b00000, 5'b01010, 5'b01111, 5'b01010}, // R5 R8
    {4'b0000, 1'b1, 5'b00101, 5'b01000, 5'b01010, 5'b00010, 5'b00010}, // R6 R9
    {4'b0000, 1'b1, 5'b11111, 5'b00000, 5'b00000, 5'b00000, 5'b00000}  // R6
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CNT_W-1:0] count_i = '0;
  logic             ovf_i = 1'b0, match_a_i = 1'b0, match_b_i = 1'b0, match_c_i = 1'b0;
  logic             cap_pin_i = 1'b0, cap_rise_i = 1'b0, cap_is_top_i = 1'b0;
  logic             clr_we_i = 1'b0;
  logic [4:0]       clr_data_i = '0, irq_en_i = '0, irq_ack_i = '0;
  logic [CNT_W-1:0] cap_val_o;
  logic [4:0]       flags_o, irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [CNT_W-1:0] exp_cap;

  always #(PERIOD/2) clk_i = ~clk_i;

  cap_flag_unit #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_cap_flag_unit (.*);

  task automatic tick();
    @(negedge clk_i);
    count_i = count_i + 16'd7;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_we_i = 1'b1; clr_data_i = 5'b11111;
    tick();
    clr_we_i = 1'b0; clr_data_i = '0;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R1 flags", {27'd0, flags_o}, 32'd0);
    chk("R1 irq", {27'd0, irq_o}, 32'd0);
    chk("R1 cap", {16'd0, cap_val_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (2) tick();

    // falling select: a rising edge is ignored
    cap_pin_i = 1'b1;
    repeat (4) tick();
    chk("R2 rise ignored cap", {16'd0, cap_val_o}, 32'd0);
    chk("R2 rise ignored flag", {31'd0, flags_o[4]}, 32'd0);

    // falling edge captured at edge k+2
    cap_pin_i = 1'b0;
    repeat (2) tick();
    chk("R3 not yet", {16'd0, cap_val_o}, 32'd0);
    exp_cap = count_i;
    tick();
    chk("R2 R3 fall value", {16'd0, cap_val_o}, {16'd0, exp_cap});
    chk("R3 flag", {31'd0, flags_o[4]}, 32'd1);
    clear_all();
    chk("R6 cap flag cleared", {27'd0, flags_o}, 32'd0);

    // rising select
    cap_rise_i = 1'b1;
    tick();
    cap_pin_i = 1'b1;
    repeat (2) tick();
    exp_cap = count_i;
    tick();
    chk("R2 rise value", {16'd0, cap_val_o}, {16'd0, exp_cap});
    chk("R2 rise flag", {31'd0, flags_o[4]}, 32'd1);
    clear_all();

    // rising select: falling edge ignored
    cap_pin_i = 1'b0;
    repeat (4) tick();
    chk("R2 fall ignored", {16'd0, cap_val_o}, {16'd0, exp_cap});
    chk("R2 fall ignored flag", {31'd0, flags_o[4]}, 32'd0);

    // blocked while capture register is TOP
    cap_is_top_i = 1'b1;
    tick();
    cap_pin_i = 1'b1;
    repeat (5) tick();
    chk("R4 value held", {16'd0, cap_val_o}, {16'd0, exp_cap});
    chk("R4 no flag", {31'd0, flags_o[4]}, 32'd0);
    cap_is_top_i = 1'b0;
    cap_pin_i = 1'b0;
    repeat (4) tick();

    // capture with interrupt, then acknowledge
    irq_en_i = 5'b10000;
    cap_pin_i = 1'b1;
    repeat (3) tick();
    chk("R8 cap irq", {27'd0, irq_o}, 32'h10);
    irq_ack_i = 5'b10000;
    tick();
    irq_ack_i = '0;
    chk("R9 cap ack", {27'd0, flags_o}, 32'd0);
    chk("R8 irq drop", {27'd0, irq_o}, 32'd0);
    irq_en_i = '0;
    clear_all();

    // flag vector table
    for (int i = 0; i < NVEC; i++) begin
      {match_c_i, match_b_i, match_a_i, ovf_i} = VEC[i][29:26];
      clr_we_i   = VEC[i][25];
      clr_data_i = VEC[i][24:20];
      irq_ack_i  = VEC[i][19:15];
      irq_en_i   = VEC[i][14:10];
      tick();
      {match_c_i, match_b_i, match_a_i, ovf_i} = 4'b0;
      clr_we_i = 1'b0; clr_data_i = '0; irq_ack_i = '0;
      chk($sformatf("R5 R6 R7 R9 vec%0d flags", i), {27'd0, flags_o}, {27'd0, VEC[i][9:5]});
      chk($sformatf("R8 vec%0d irq", i), {27'd0, irq_o}, {27'd0, VEC[i][4:0]});
    end

    // async reset mid-run
    match_a_i = 1'b1;
    tick();
    match_a_i = 1'b0;
    rst_ni = 1'b0;
    tick();
    chk("R1 reset again", {27'd0, flags_o}, 32'd0);
    chk("R1 cap reset", {16'd0, cap_val_o}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule